// File: doc/BRIEF.md
# Programmable 3x3 Colour Space Converter

This block turns a stream of three-component pixels into another colour space, for example luma/chroma into red/green/blue. Each pixel carries a layer index, and every layer owns its own programmable conversion: a 3x3 matrix of signed multiplication factors, three per-input differences that are added to the inputs before they are multiplied, and three per-output constants that are added after the products are summed. Software loads these values through a plain 32-bit write port. A control word holds one enable bit per layer, and a layer whose bit is clear passes its pixels through unchanged.

The pixel path is a valid/ready stream with a fixed three-stage pipeline. The first stage captures the pixel together with a snapshot of its layer's configuration and forms the offset inputs. The second stage forms the nine products. The third stage sums the products, adds the constant, rounds, and clamps the result to the unsigned 10-bit output range. All three stages move together, and a stalled output holds the whole pipeline.

Top module: `csc_matrix3x3`

## Requirements
- R1: After reset `out_valid` is 0, `in_ready` is 1, every matrix word is zero and every enable bit is clear, so all layers bypass.
- R2: The control word sits at byte address 0x100, and bit L enables layer L. Layer L's word w (0..3) of row r (0..2) sits at 0x110 + L*0x30 + r*0x10 + w*4. A write to any other address changes nothing.
- R3: Words 0..2 of row r are the signed factors c_r0, c_r1, c_r2 with 17 fractional bits. Word 3 of row r holds the signed 16-bit difference d_r in bits 31:16, which is added to input r, and the signed 16-bit constant k_r in bits 15:0, which is in output units. Output r = c_r0*(in0+d0) + c_r1*(in1+d1) + c_r2*(in2+d2) + k_r. Inputs are zero-extended 10-bit values.
- R4: Output r is rounded by adding 2^16 to the full-precision sum, which has 17 fractional bits, and then shifting it arithmetically right by 17, so an exact half rounds upward.
- R5: Each rounded output is clamped to 0..1023.
- R6: When the enable bit of the pixel's layer is clear, the outputs equal the inputs.
- R7: With `out_ready` held at 1, a pixel accepted at clock edge k is presented with `out_valid` = 1 after edge k+2 and not before.
- R8: While `out_valid` is 1 and `out_ready` is 0, the outputs hold steady and `in_ready` is 0.
- R9: A register write on the same edge as a pixel's acceptance does not affect that pixel. The next pixel accepted uses the new value.
- R10: With the factors 0x2542a/0/0x3312a/0xffc00000, 0x2542a/0xffff376b/0xfffe5fc3/0xfe000000 and 0x2542a/0x408d3/0/0xfe000000 loaded, inputs (64,512,512), (940,512,512) and (500,600,400) give (0,0,0), (1020,1020,1020) and (329,564,685). Swapping factor columns 1 and 2 gives the same results for inputs given in the order (in0,in2,in1).
- R11: `in_layer` chooses both the matrix block and the enable bit, so pixels of different layers use independent configurations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register byte address |
| wr_data | input | 32 | Register write data |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_layer | input | 2 | Layer index of the input pixel |
| in_c0 | input | 10 | Input component 0 |
| in_c1 | input | 10 | Input component 1 |
| in_c2 | input | 10 | Input component 2 |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream can take the output pixel |
| out_c0 | output | 10 | Output component 0 |
| out_c1 | output | 10 | Output component 1 |
| out_c2 | output | 10 | Output component 2 |

## Verification
A register write and a pixel acceptance can land on the same clock edge. The hazard is that the pixel picks up the half-written configuration. The bench drives a control write that enables a bypassing layer in the same cycle as a pixel of that layer, then sends a second pixel of the same layer in the next cycle. The first pixel must come out as its own inputs and the second as the zero-matrix result, which shows that the snapshot taken at acceptance saw the old enable bit and the next acceptance saw the new one. A back-pressure window likewise overlaps a full pipeline with a blocked input, and the bench judges it by held outputs and a low `in_ready`.

// File: rtl/csc_pkg.sv
package csc_pkg;

    // Component and arithmetic widths
    localparam int PIX_W   = 10;              // unsigned input/output component
    localparam int COEF_W  = 32;              // register word / factor width
    localparam int FRAC_W  = 17;              // fractional bits of each factor
    localparam int HALF_W  = 16;              // difference and constant width
    localparam int ROWS    = 3;
    localparam int WORDS   = 4;
    localparam int TERMS   = 3;

    // Derived widths
    localparam int DIFF_W  = HALF_W + 1;      // input + difference, signed
    localparam int PROD_W  = DIFF_W + COEF_W; // one full-precision product
    localparam int ACC_W   = PROD_W + 2;      // three products + constant + round

    typedef logic [COEF_W-1:0]        word_t;
    typedef logic [PIX_W-1:0]         pix_t;
    typedef logic signed [DIFF_W-1:0] diff_t;
    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic signed [HALF_W-1:0] half_t;

endpackage

// File: rtl/csc_regfile.sv
module csc_regfile
    import csc_pkg::*;
#(
    parameter int          NUM_LAYERS   = 4,
    parameter int          ADDR_W       = 12,
    parameter int unsigned CTRL_ADDR    = 32'h100,
    parameter int unsigned BLOCK_BASE   = 32'h110,
    parameter int unsigned BLOCK_STRIDE = 32'h30,
    parameter int unsigned ROW_STRIDE   = 32'h10,
    parameter int unsigned WORD_STRIDE  = 32'h4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  word_t             wr_data,
    output logic [NUM_LAYERS-1:0] en_q,
    output word_t             tbl_q [NUM_LAYERS][ROWS][WORDS]
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    function automatic logic [ADDR_W-1:0] word_addr(int l, int r, int w);
        return ADDR_W'(BLOCK_BASE + l * BLOCK_STRIDE + r * ROW_STRIDE + w * WORD_STRIDE);
    endfunction

    // Enable bits, one per layer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en && (wr_addr == CTRL_A)) begin
            en_q <= wr_data[NUM_LAYERS-1:0];
        end
    end

    // Matrix words, decoded by full address compare
    always_ff @(posedge clk) begin
        for (int l = 0; l < NUM_LAYERS; l++) begin
            for (int r = 0; r < ROWS; r++) begin
                for (int w = 0; w < WORDS; w++) begin
                    if (!rst_n) begin
                        tbl_q[l][r][w] <= '0;
                    end else if (wr_en && (wr_addr == word_addr(l, r, w))) begin
                        tbl_q[l][r][w] <= wr_data;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/csc_flow.sv
module csc_flow (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic adv,
    output logic in_ready,
    output logic out_valid
);

    logic s1_v, s2_v, s3_v;

    // Whole pipe steps together unless the last stage is held
    assign adv       = !s3_v || out_ready;
    assign in_ready  = adv;
    assign out_valid = s3_v;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v <= 1'b0;
            s2_v <= 1'b0;
            s3_v <= 1'b0;
        end else if (adv) begin
            s1_v <= in_valid;
            s2_v <= s1_v;
            s3_v <= s2_v;
        end
    end

endmodule

// File: rtl/csc_row.sv
module csc_row
    import csc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  adv,
    input  diff_t s1_diff [TERMS],
    input  word_t s1_coef [TERMS],
    input  half_t s1_cst,
    input  logic  s1_byp,
    input  pix_t  s1_pix,
    output pix_t  out_pix
);

    localparam acc_t ROUND_HALF = acc_t'(1) <<< (FRAC_W - 1);
    localparam acc_t OUT_MAX    = acc_t'((1 << PIX_W) - 1);

    prod_t s2_prod [TERMS];
    half_t s2_cst;
    logic  s2_byp;
    pix_t  s2_pix;

    acc_t  acc_sum;
    acc_t  acc_int;
    pix_t  sat_val;

    // Stage 2: products at full precision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < TERMS; k++) s2_prod[k] <= '0;
            s2_cst <= '0;
            s2_byp <= 1'b1;
            s2_pix <= '0;
        end else if (adv) begin
            for (int k = 0; k < TERMS; k++) begin
                s2_prod[k] <= prod_t'(s1_diff[k]) * prod_t'($signed(s1_coef[k]));
            end
            s2_cst <= s1_cst;
            s2_byp <= s1_byp;
            s2_pix <= s1_pix;
        end
    end

    // Sum, align constant, round half up, then clamp
    always_comb begin
        acc_sum = ROUND_HALF + (acc_t'(s2_cst) <<< FRAC_W);
        for (int k = 0; k < TERMS; k++) begin
            acc_sum = acc_sum + acc_t'(s2_prod[k]);
        end
        acc_int = acc_sum >>> FRAC_W;
        if (acc_int < 0) begin
            sat_val = '0;
        end else if (acc_int > OUT_MAX) begin
            sat_val = '1;
        end else begin
            sat_val = acc_int[PIX_W-1:0];
        end
    end

    // Stage 3: output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_pix <= '0;
        end else if (adv) begin
            out_pix <= s2_byp ? s2_pix : sat_val;
        end
    end

endmodule

// File: rtl/csc_matrix3x3.sv
module csc_matrix3x3
    import csc_pkg::*;
#(
    parameter int NUM_LAYERS = 4,
    parameter int ADDR_W     = 12,
    localparam int LAYER_W   = (NUM_LAYERS > 1) ? $clog2(NUM_LAYERS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [31:0]        wr_data,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [LAYER_W-1:0] in_layer,
    input  logic [9:0]         in_c0,
    input  logic [9:0]         in_c1,
    input  logic [9:0]         in_c2,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [9:0]         out_c0,
    output logic [9:0]         out_c1,
    output logic [9:0]         out_c2
);

    logic [NUM_LAYERS-1:0] en_q;
    word_t tbl_q [NUM_LAYERS][ROWS][WORDS];
    logic  adv;

    pix_t  in_pix   [TERMS];
    diff_t in_diff  [TERMS];

    // Stage 1 state: offset inputs plus configuration snapshot
    pix_t  s1_pix   [TERMS];
    diff_t s1_diff  [TERMS];
    logic  s1_byp;
    word_t s1_coef  [ROWS][TERMS];
    half_t s1_cst   [ROWS];
    pix_t  row_out  [ROWS];

    csc_regfile #(
        .NUM_LAYERS (NUM_LAYERS),
        .ADDR_W     (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .en_q    (en_q),
        .tbl_q   (tbl_q)
    );

    csc_flow u_flow (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .adv       (adv),
        .in_ready  (in_ready),
        .out_valid (out_valid)
    );

    assign in_pix[0] = in_c0;
    assign in_pix[1] = in_c1;
    assign in_pix[2] = in_c2;

    // Difference for input k lives in the upper half of row k, word 3
    always_comb begin
        for (int k = 0; k < TERMS; k++) begin
            in_diff[k] = $signed({{(DIFF_W-PIX_W){1'b0}}, in_pix[k]})
                       + diff_t'($signed(tbl_q[in_layer][k][WORDS-1][COEF_W-1 -: HALF_W]));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_byp <= 1'b1;
            for (int k = 0; k < TERMS; k++) begin
                s1_pix[k]  <= '0;
                s1_diff[k] <= '0;
            end
            for (int r = 0; r < ROWS; r++) begin
                s1_cst[r] <= '0;
                for (int k = 0; k < TERMS; k++) s1_coef[r][k] <= '0;
            end
        end else if (adv) begin
            s1_byp <= !en_q[in_layer];
            for (int k = 0; k < TERMS; k++) begin
                s1_pix[k]  <= in_pix[k];
                s1_diff[k] <= in_diff[k];
            end
            for (int r = 0; r < ROWS; r++) begin
                s1_cst[r] <= $signed(tbl_q[in_layer][r][WORDS-1][HALF_W-1:0]);
                for (int k = 0; k < TERMS; k++) s1_coef[r][k] <= tbl_q[in_layer][r][k];
            end
        end
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        csc_row u_row (
            .clk     (clk),
            .rst_n   (rst_n),
            .adv     (adv),
            .s1_diff (s1_diff),
            .s1_coef (s1_coef[r]),
            .s1_cst  (s1_cst[r]),
            .s1_byp  (s1_byp),
            .s1_pix  (s1_pix[r]),
            .out_pix (row_out[r])
        );
    end

    assign out_c0 = row_out[0];
    assign out_c1 = row_out[1];
    assign out_c2 = row_out[2];

endmodule

// File: rtl/csc_matrix3x3_chk.sv
module csc_matrix3x3_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic       out_valid,
    input logic       out_ready,
    input logic [9:0] out_c0,
    input logic [9:0] out_c1,
    input logic [9:0] out_c2
);

    logic [2:0] occ_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_q + 3'((in_valid && in_ready) ? 1 : 0)
                           - 3'((out_valid && out_ready) ? 1 : 0);
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);

    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_c0)
                                      && $stable(out_c1) && $stable(out_c2)));

    // R8
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R7
    occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= 3'd3);

    // R7
    no_phantom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (occ_q != 3'd0));

endmodule

bind csc_matrix3x3 csc_matrix3x3_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_c0    (out_c0),
    .out_c1    (out_c1),
    .out_c2    (out_c2)
);

// File: tb/csc_matrix3x3_tb.sv
module csc_matrix3x3_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_layer = '0;
    logic [9:0]  in_c0 = '0, in_c1 = '0, in_c2 = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [9:0]  out_c0, out_c1, out_c2;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;  // 250 MHz

    csc_matrix3x3 u_dut (
        .clk (clk), .rst_n (rst_n),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .in_valid (in_valid), .in_ready (in_ready), .in_layer (in_layer),
        .in_c0 (in_c0), .in_c1 (in_c1), .in_c2 (in_c2),
        .out_valid (out_valid), .out_ready (out_ready),
        .out_c0 (out_c0), .out_c1 (out_c1), .out_c2 (out_c2)
    );

    // {layer, in0, in1, in2, exp0, exp1, exp2}
    localparam int NV = 14;
    localparam logic [61:0] VECS [NV] = '{
        {2'd0, 10'd64,   10'd512,  10'd512,  10'd0,    10'd0,    10'd0},    // R10
        {2'd0, 10'd940,  10'd512,  10'd512,  10'd1020, 10'd1020, 10'd1020}, // R10
        {2'd0, 10'd500,  10'd600,  10'd400,  10'd329,  10'd564,  10'd685},  // R10 R3
        {2'd0, 10'd1023, 10'd512,  10'd512,  10'd1023, 10'd1023, 10'd1023}, // R5 high
        {2'd0, 10'd0,    10'd512,  10'd512,  10'd0,    10'd0,    10'd0},    // R5 low
        {2'd0, 10'd64,   10'd512,  10'd1023, 10'd816,  10'd0,    10'd0},    // R3
        {2'd0, 10'd64,   10'd800,  10'd512,  10'd0,    10'd0,    10'd581},  // R3
        {2'd2, 10'd64,   10'd1023, 10'd512,  10'd816,  10'd0,    10'd0},    // R10 swapped
        {2'd2, 10'd500,  10'd400,  10'd600,  10'd329,  10'd564,  10'd685},  // R10 swapped
        {2'd1, 10'd3,    10'd30,   10'd7,    10'd7,    10'd7,    10'd7},    // R4 half up
        {2'd1, 10'd2,    10'd30,   10'd7,    10'd6,    10'd7,    10'd7},    // R4 exact
        {2'd1, 10'd3,    10'd10,   10'd1000, 10'd7,    10'd0,    10'd1000}, // R5 R3 const
        {2'd1, 10'd1023, 10'd1023, 10'd1023, 10'd517,  10'd1000, 10'd1023}, // R3 R11
        {2'd3, 10'd123,  10'd456,  10'd789,  10'd123,  10'd456,  10'd789}   // R6 R11
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Send one pixel, check exact latency (R7) and the result
    task automatic send(input string req, input logic [1:0] l,
                        input int a, input int b, input int c,
                        input int e0, input int e1, input int e2);
        @(negedge clk);
        in_layer = l; in_c0 = 10'(a); in_c1 = 10'(b); in_c2 = 10'(c);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R7 early", int'(out_valid), 0);
        @(negedge clk);
        chk("R7 valid", int'(out_valid), 1);
        chk(req, int'(out_c0), e0);
        chk(req, int'(out_c1), e1);
        chk(req, int'(out_c2), e2);
    endtask

    task automatic load_layer(input logic [11:0] base, input logic [31:0] w [12]);
        for (int i = 0; i < 12; i++) begin
            wr(base + 12'((i / 4) * 16 + (i % 4) * 4), w[i]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R7 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] yuv [12];
        logic [31:0] yvu [12];
        logic [31:0] cus [12];
        yuv = '{32'h2542a, 32'h0,        32'h3312a,   32'hffc00000,
                32'h2542a, 32'hffff376b, 32'hfffe5fc3, 32'hfe000000,
                32'h2542a, 32'h408d3,    32'h0,        32'hfe000000};
        yvu = '{32'h2542a, 32'h3312a,    32'h0,        32'hffc00000,
                32'h2542a, 32'hfffe5fc3, 32'hffff376b, 32'hfe000000,
                32'h2542a, 32'h0,        32'h408d3,    32'hfe000000};
        cus = '{32'h10000, 32'h0,        32'h0,        32'h00000005,
                32'h0,     32'h20000,    32'h0,        32'hfffdffec,
                32'h0,     32'h0,        32'h20000,    32'h0};

        repeat (3) @(negedge clk);
        chk("R1 out_valid", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid", int'(out_valid), 0);
        chk("R1 in_ready", int'(in_ready), 1);
        send("R1 bypass", 2'd0, 100, 200, 300, 100, 200, 300);

        load_layer(12'h110, yuv);
        load_layer(12'h140, cus);
        load_layer(12'h170, yvu);
        wr(12'h100, 32'h7);

        for (int v = 0; v < NV; v++) begin
            send($sformatf("R3/R10 vector %0d", v), VECS[v][61:60],
                 int'(VECS[v][59:50]), int'(VECS[v][49:40]), int'(VECS[v][39:30]),
                 int'(VECS[v][29:20]), int'(VECS[v][19:10]), int'(VECS[v][9:0]));
        end

        // R2: writes off the map change nothing
        wr(12'h104, 32'hffffffff);
        wr(12'h1d0, 32'hffffffff);
        wr(12'h10c, 32'hffffffff);
        send("R2 ignored ctrl", 2'd3, 11, 22, 33, 11, 22, 33);
        send("R2 ignored word", 2'd0, 500, 600, 400, 329, 564, 685);

        // R9: write and acceptance on the same edge
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 12'h100; wr_data = 32'hf;
        in_layer = 2'd3; in_c0 = 10'd10; in_c1 = 10'd20; in_c2 = 10'd30;
        in_valid = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        in_c0 = 10'd40; in_c1 = 10'd50; in_c2 = 10'd60;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk("R9 old pixel valid", int'(out_valid), 1);
        chk("R9 old pixel", int'(out_c0), 10);
        chk("R9 old pixel", int'(out_c2), 30);
        @(negedge clk);
        chk("R9 new pixel valid", int'(out_valid), 1);
        chk("R9 new pixel", int'(out_c0), 0);
        chk("R9 new pixel", int'(out_c1), 0);
        wr(12'h100, 32'h7);

        // R8: back-pressure
        @(negedge clk);
        out_ready = 1'b0;
        in_layer = 2'd3; in_c0 = 10'd111; in_c1 = 10'd222; in_c2 = 10'd333;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (5) @(negedge clk);
        chk("R8 held valid", int'(out_valid), 1);
        chk("R8 in_ready low", int'(in_ready), 0);
        chk("R8 held data", int'(out_c1), 222);
        out_ready = 1'b1;
        @(negedge clk);
        chk("R8 drained", int'(out_valid), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule